// File: doc/BRIEF.md
# Byte-Serial Lookup-Table CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a message presented one byte per clock. It holds a 32-bit remainder register. For each accepted byte the register moves left by eight bits and the new byte fills the vacated low byte. The byte pushed out of the top selects one of 256 precomputed words, and that word is XORed into the register. All 256 words are derived at elaboration from the generator polynomial, so no stored file is needed.

The engine implements the augmented form of the division. Once the last message byte is in, the engine feeds four zero bytes into the register by itself. During those four cycles it refuses further input. It then signals completion for one clock, and the register holds the remainder of the zero-padded message divided by the generator. Bit reflection, a preset register value and an output inversion are not part of this block.

A client raises `start_i` for one cycle, streams bytes with a valid/ready handshake, marks the final byte, and waits for `done_o`.

Top module: `crc32_lut_engine`

## Requirements
- R1: After reset `in_ready_o` is 0, `done_o` is 0 and `crc_o` is 0x00000000.
- R2: A cycle with `start_i` high clears the remainder register to 0x00000000 and makes `in_ready_o` 1 from the next cycle on.
- R3: A byte D accepted while the register holds C sets the register to ((C << 8) | D) XOR T[C[31:24]]. The operation is modulo 2^32. T[i] is the remainder of i·x^32 divided by the generator x^32 + 0x04C11DB7, with the bits written most significant first.
- R4: A cycle in which `in_valid_i` is low, or `in_ready_o` is low, leaves the register unchanged, except for flush steps and `start_i`.
- R5: Accepting a byte with `in_last_i` high starts four flush steps that each apply R3 with D = 0. `in_ready_o` is 0 during those four cycles and stays 0 until the next `start_i`.
- R6: A byte offered during the flush, with or without `in_last_i`, has no effect on the result.
- R7: `done_o` is high for exactly one cycle: the fifth cycle after the edge that accepts the last byte. At that point `crc_o` equals the bit-serial remainder of the message followed by 32 zero bits, divided by the generator, with the register starting at 0.
- R8: After `done_o`, `crc_o` keeps the result until the next `start_i`.
- R9: `start_i` wins in every state. A new start during a message or during a flush discards the earlier work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new message; clears the remainder |
| in_valid_i | input | 1 | A byte is offered on `in_data_i` |
| in_data_i | input | 8 | Message byte |
| in_last_i | input | 1 | The offered byte ends the message |
| in_ready_o | output | 1 | Engine accepts a byte this cycle |
| done_o | output | 1 | One-cycle pulse: remainder is final |
| crc_o | output | 32 | Remainder register |

## Verification
Every one-byte message from 0x00 to 0xFF is run, which reaches each of the 256 table words once on its own. Two-byte messages with a second byte derived from the first, and messages of length 1 to 16, show that the entries combine correctly and that the byte order is kept. Some runs insert idle bubbles carrying inverted data, and some offer junk bytes flagged as last during the flush. Both must give the same remainder as the clean run, which separates real acceptance from stray capture. Restarts in the middle of a message and in the middle of a flush must leave only the second message in the result.

// File: rtl/crc32b_pkg.sv
package crc32b_pkg;

    localparam int CRC_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int LUT_N   = 1 << BYTE_W;
    localparam int FLUSH_N = CRC_W / BYTE_W;
    localparam int CNT_W   = $clog2(FLUSH_N);

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } seq_st_e;

    // Remainder of idx * x^CRC_W modulo the generator (implicit top term).
    function automatic crc_t lut_entry(input byte_t idx, input crc_t poly);
        crc_t r;
        r = crc_t'(idx) << (CRC_W - BYTE_W);
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[CRC_W-1]) r = (r << 1) ^ poly;
            else            r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_lut.sv
module crc_lut
    import crc32b_pkg::*;
#(
    parameter crc_t POLY = 32'h04C11DB7
) (
    input  byte_t idx_i,
    output crc_t  ent_o
);

    crc_t tbl [LUT_N];

    for (genvar gi = 0; gi < LUT_N; gi++) begin : g_ent
        assign tbl[gi] = lut_entry(byte_t'(gi), POLY);
    end

    always_comb begin
        ent_o = tbl[idx_i];
    end

endmodule

// File: rtl/crc_step.sv
module crc_step
    import crc32b_pkg::*;
(
    input  crc_t  crc_i,
    input  byte_t byte_i,
    input  crc_t  ent_i,
    output byte_t top_o,
    output crc_t  crc_o
);

    always_comb begin
        top_o = crc_i[CRC_W-1 -: BYTE_W];
        crc_o = {crc_i[CRC_W-BYTE_W-1:0], byte_i} ^ ent_i;
    end

endmodule

// File: rtl/crc_seq.sv
module crc_seq
    import crc32b_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic last_i,
    output logic ready_o,
    output logic done_o,
    output logic clr_o,
    output logic step_o,
    output logic zero_o
);

    typedef struct packed {
        seq_st_e st;
        cnt_t    cnt;
        logic    done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.done = 1'b0;
        clr_o  = 1'b0;
        step_o = 1'b0;
        zero_o = 1'b0;
        if (start_i) begin
            clr_o  = 1'b1;
            s_d.st = ST_RUN;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.st)
                ST_RUN: begin
                    if (valid_i) begin
                        step_o = 1'b1;
                        if (last_i) begin
                            s_d.st  = ST_FLUSH;
                            s_d.cnt = '0;
                        end
                    end
                end
                ST_FLUSH: begin
                    step_o = 1'b1;
                    zero_o = 1'b1;
                    if (s_q.cnt == cnt_t'(FLUSH_N - 1)) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + cnt_t'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0, done: 1'b0};
        else        s_q <= s_d;
    end

    assign ready_o = (s_q.st == ST_RUN);
    assign done_o  = s_q.done;

    // R5: the edge that takes the last byte drops ready for the flush
    p_last_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i && last_i && !start_i) |=> !ready_o);

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: the flush counter only runs while in the flush state
    p_cnt_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_FLUSH && !start_i && !(ready_o && valid_i && last_i))
            |=> (s_q.st != ST_FLUSH));

endmodule

// File: rtl/crc32_lut_engine.sv
module crc32_lut_engine
    import crc32b_pkg::*;
#(
    parameter crc_t POLY = 32'h04C11DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        in_valid_i,
    input  logic [7:0]  in_data_i,
    input  logic        in_last_i,
    output logic        in_ready_o,
    output logic        done_o,
    output logic [31:0] crc_o
);

    typedef struct packed {
        crc_t rem;
    } dp_t;

    dp_t   dp_d, dp_q;
    logic  clr, step, zero;
    byte_t top_byte, feed_byte;
    crc_t  ent, stepped;

    crc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (in_valid_i),
        .last_i  (in_last_i),
        .ready_o (in_ready_o),
        .done_o  (done_o),
        .clr_o   (clr),
        .step_o  (step),
        .zero_o  (zero)
    );

    crc_lut #(.POLY(POLY)) u_lut (
        .idx_i (top_byte),
        .ent_o (ent)
    );

    crc_step u_step (
        .crc_i  (dp_q.rem),
        .byte_i (feed_byte),
        .ent_i  (ent),
        .top_o  (top_byte),
        .crc_o  (stepped)
    );

    always_comb begin
        dp_d      = dp_q;
        feed_byte = zero ? '0 : in_data_i;
        if (clr)       dp_d.rem = '0;
        else if (step) dp_d.rem = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign crc_o = dp_q.rem;

    // R2: a start leaves a cleared remainder and an open input
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (crc_o == '0) && in_ready_o);

    // R4: no byte and no start keeps the remainder while input is open
    p_bubble_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !in_valid_i && !start_i) |=> $stable(crc_o));

    // R8: the result stays after the completion pulse
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(crc_o));

    // R7: completion never coincides with open input
    p_done_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o);

endmodule

// File: tb/crc32_lut_engine_bench.sv
module crc32_lut_engine_bench;

    localparam logic [31:0] GEN = 32'h04C11DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = 8'h00;
    logic        in_last_i = 1'b0;
    logic        in_ready_o;
    logic        done_o;
    logic [31:0] crc_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] msg [0:15];

    always #10 clk = ~clk;

    crc32_lut_engine u_crc32_lut_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .in_last_i  (in_last_i),
        .in_ready_o (in_ready_o),
        .done_o     (done_o),
        .crc_o      (crc_o)
    );

    // Long division of msg[0..n-1] followed by 32 zero bits, bit by bit.
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] r;
        logic [7:0]  b;
        logic        msb;
        r = '0;
        for (int i = 0; i < n + 4; i++) begin
            b = (i < n) ? msg[i] : 8'h00;
            for (int k = 7; k >= 0; k--) begin
                msb = r[31];
                r = {r[30:0], b[k]};
                if (msb) r = r ^ GEN;
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_msg(input int n, input bit gaps, input bit junk);
        logic [31:0] exp;
        exp = ref_crc(n);
        @(negedge clk);
        start_i = 1'b1; in_valid_i = 1'b0; in_last_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(in_ready_o == 1'b1, "R2 ready", 32'(in_ready_o), 32'd1);
        check(crc_o == 32'h0, "R2 clear", crc_o, 32'h0);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                in_valid_i = 1'b0; in_data_i = ~msg[i]; in_last_i = 1'b1;
                @(negedge clk);
            end
            in_valid_i = 1'b1; in_data_i = msg[i]; in_last_i = (i == n - 1);
            @(negedge clk);
        end
        for (int k = 1; k <= 4; k++) begin
            check(in_ready_o == 1'b0, "R5 ready low in flush", 32'(in_ready_o), 32'd0);
            check(done_o == 1'b0, "R7 early done", 32'(done_o), 32'd0);
            if (junk) begin
                in_valid_i = 1'b1; in_data_i = 8'hA5 ^ 8'(k); in_last_i = 1'b1;
            end else begin
                in_valid_i = 1'b0; in_last_i = 1'b0;
            end
            @(negedge clk);
        end
        in_valid_i = 1'b0; in_last_i = 1'b0;
        check(done_o == 1'b1, "R7 done pulse", 32'(done_o), 32'd1);
        check(crc_o == exp, junk ? "R6 result" : (gaps ? "R4 result" : "R3 R7 result"),
              crc_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R7 single pulse", 32'(done_o), 32'd0);
        check(crc_o == exp, "R8 hold", crc_o, exp);
        in_valid_i = 1'b1; in_data_i = 8'h3C;
        @(negedge clk);
        in_valid_i = 1'b0;
        check(crc_o == exp, "R8 hold idle", crc_o, exp);
        check(in_ready_o == 1'b0, "R5 ready stays low", 32'(in_ready_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready_o == 1'b0, "R1 ready", 32'(in_ready_o), 32'd0);
        check(done_o == 1'b0, "R1 done", 32'(done_o), 32'd0);
        check(crc_o == 32'h0, "R1 crc", crc_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 1'b0, "R1 idle before start", 32'(in_ready_o), 32'd0);

        // R3: every single-byte message reaches each table word
        for (int v = 0; v < 256; v++) begin
            msg[0] = 8'(v);
            run_msg(1, 1'b0, 1'b0);
        end
        // R3: two-byte pairs
        for (int v = 0; v < 256; v++) begin
            msg[0] = 8'(v);
            msg[1] = 8'((v * 37 + 11) & 255);
            run_msg(2, 1'b0, (v % 4) == 0);
        end
        // R3 R4 R6: length sweep with bubbles and junk in flush
        for (int n = 1; n <= 16; n++) begin
            for (int i = 0; i < 16; i++) msg[i] = 8'((i * 73 + n * 19 + 5) & 255);
            run_msg(n, 1'b0, 1'b0);
            run_msg(n, 1'b1, 1'b0);
            run_msg(n, 1'b1, 1'b1);
        end

        // R9: restart in the middle of a message
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_valid_i = 1'b1; in_data_i = 8'hF0 + 8'(i); in_last_i = 1'b0;
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        for (int i = 0; i < 5; i++) msg[i] = 8'(i * 51 + 7);
        run_msg(5, 1'b0, 1'b0);

        // R9: restart in the middle of a flush
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        in_valid_i = 1'b1; in_data_i = 8'h99; in_last_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        @(negedge clk);
        check(in_ready_o == 1'b0, "R9 in flush", 32'(in_ready_o), 32'd0);
        msg[0] = 8'h12; msg[1] = 8'h34; msg[2] = 8'h56;
        run_msg(3, 1'b0, 1'b0);

        // R3: an all-zero message leaves a zero remainder
        for (int i = 0; i < 8; i++) msg[i] = 8'h00;
        run_msg(8, 1'b0, 1'b0);
        check(crc_o == 32'h0, "R3 zero message", crc_o, 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule